// File: doc/BRIEF.md
# Thermal-Level Memory Throttle Duty Controller

This block cuts memory bandwidth in proportion to how hot the memory subsystem runs. Time is split into repeating throttle windows of a programmable length. During the first N clocks of each window, the block withholds every read and write grant. It passes requests through for the rest of the window. N comes from a per-level throttle count, chosen by a 3-bit thermal level that an external trip comparator supplies together with a valid flag.

Two 32-bit words hold eight 8-bit throttle counts, one for each thermal level. The hottest level should be programmed with the largest count, and each cooler level with a smaller one. The block samples the level, the counts, the valid flag and the window length only at a window boundary. A window already in progress is therefore never cut short or stretched.

Top module: `mem_thermal_throttle`

## Requirements
- R1: While reset is asserted, and for the first window after it, throttle_o is low and every grant follows its request. That first window is 32 clocks long.
- R2: The window length is win_len_i + 1 clocks, with a minimum of 32: a field value below 31 gives 32, and 255 gives 256. The length takes effect at the next window boundary.
- R3: Level code 0 is the hottest level, and code k (1 to 7) is k steps cooler. Codes 0 to 3 select cnt_hot_i bytes [31:24], [23:16], [15:8] and [7:0]. Codes 4 to 7 select cnt_cool_i bytes [31:24], [23:16], [15:8] and [7:0].
- R4: With a valid trip, throttle_o is high for exactly the first N clocks of each window, where N is the selected count, and low for the rest of the window.
- R5: If N is equal to or greater than the window length, throttle_o stays high for the whole window.
- R6: If trip_vld_i is low at a window boundary, the next window carries no throttling.
- R7: Changes to the level, the counts or the valid flag during a window do not affect that window. They apply from the next window.
- R8: rd_gnt_o = rd_req_i and wr_gnt_o = wr_req_i, except while throttle_o is high, when both grants are low.
- R9: A selected count of 00h produces no throttling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_hot_i | input | 32 | Throttle counts for level codes 0..3 |
| cnt_cool_i | input | 32 | Throttle counts for level codes 4..7 |
| win_len_i | input | 8 | Window length minus one |
| level_i | input | 3 | Thermal level code |
| trip_vld_i | input | 1 | Level is a valid trip |
| rd_req_i | input | 1 | Read request |
| wr_req_i | input | 1 | Write request |
| rd_gnt_o | output | 1 | Gated read grant |
| wr_gnt_o | output | 1 | Gated write grant |
| throttle_o | output | 1 | Throttle active |

## Verification
The assertions check the following on every cycle:
- the window counter never passes the latched last index, and that index never falls below 31;
- the latched count and length stay constant inside a window;
- throttling can only begin at a window start;
- an invalid trip at a boundary loads a zero count;
- no grant is issued while throttling.

Only the bench's scenarios can show the rest:
- that the correct byte is chosen for each level code;
- that the number of throttled clocks per window equals min(N, length);
- that the length clamping and encoding are right;
- that a change in mid-window takes effect exactly one boundary later.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  localparam int CNT_W   = 8;
  localparam int NUM_LVL = 8;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int MIN_LEN = 32;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/mtt_level_sel.sv
module mtt_level_sel
  import mtt_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int NL = NUM_LVL
) (
  input  logic [NL/2*CW-1:0] cnt_hot_i,
  input  logic [NL/2*CW-1:0] cnt_cool_i,
  input  logic [$clog2(NL)-1:0] level_i,
  output logic [CW-1:0]      sel_o
);
  localparam int HALF = NL / 2;

  logic [CW-1:0] tbl [NL];

  // hottest level sits in the top byte of each word
  for (genvar g = 0; g < NL; g++) begin : g_lvl
    if (g < HALF) begin : g_hot
      assign tbl[g] = cnt_hot_i[(HALF-1-g)*CW +: CW];
    end else begin : g_cool
      assign tbl[g] = cnt_cool_i[(NL-1-g)*CW +: CW];
    end
  end

  assign sel_o = tbl[level_i];
endmodule

// File: rtl/mtt_window.sv
module mtt_window
  import mtt_pkg::*;
#(
  parameter int CW   = CNT_W,
  parameter int MINL = MIN_LEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] sel_cnt_i,
  input  logic          trip_vld_i,
  input  logic [CW-1:0] win_len_i,
  output logic          throttle_o
);
  localparam logic [CW-1:0] MIN_LAST = CW'(MINL - 1);

  logic [CW-1:0] pos_q, last_q, act_q, last_d;
  logic          wrap;

  assign last_d = (win_len_i < MIN_LAST) ? MIN_LAST : win_len_i;
  assign wrap   = (pos_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      last_q <= MIN_LAST;
      act_q  <= '0;
    end else if (wrap) begin
      pos_q  <= '0;
      last_q <= last_d;
      act_q  <= trip_vld_i ? sel_cnt_i : '0;
    end else begin
      pos_q  <= pos_q + 1'b1;
    end
  end

  // count >= length throttles the whole window since pos_q <= last_q
  assign throttle_o = (pos_q < act_q);

  a_r2_pos_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= last_q);
  a_r2_min_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_q >= MIN_LAST);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q != '0) |-> ($stable(act_q) && $stable(last_q)));
  a_r4_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(throttle_o) |-> (pos_q == '0));
  a_r6_no_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !trip_vld_i) |=> (act_q == '0));
endmodule

// File: rtl/mem_thermal_throttle.sv
module mem_thermal_throttle
  import mtt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] cnt_hot_i,
  input  logic [31:0] cnt_cool_i,
  input  logic [7:0]  win_len_i,
  input  logic [2:0]  level_i,
  input  logic        trip_vld_i,
  input  logic        rd_req_i,
  input  logic        wr_req_i,
  output logic        rd_gnt_o,
  output logic        wr_gnt_o,
  output logic        throttle_o
);
  cnt_t sel_cnt;

  mtt_level_sel #(.CW(CNT_W), .NL(NUM_LVL)) u_sel (
    .cnt_hot_i (cnt_hot_i),
    .cnt_cool_i(cnt_cool_i),
    .level_i   (level_i),
    .sel_o     (sel_cnt)
  );

  mtt_window #(.CW(CNT_W), .MINL(MIN_LEN)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_cnt_i (sel_cnt),
    .trip_vld_i(trip_vld_i),
    .win_len_i (win_len_i),
    .throttle_o(throttle_o)
  );

  assign rd_gnt_o = rd_req_i & ~throttle_o;
  assign wr_gnt_o = wr_req_i & ~throttle_o;

  a_r8_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    throttle_o |-> (!rd_gnt_o && !wr_gnt_o));
  a_r8_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!throttle_o && rd_req_i) |-> rd_gnt_o);
endmodule

// File: tb/sim_mem_thermal_throttle.sv
module sim_mem_thermal_throttle;
  logic        clk = 0, rst_ni = 0;
  logic [31:0] cnt_hot = 0, cnt_cool = 0;
  logic [7:0]  win_len = 0;
  logic [2:0]  level = 0;
  logic        trip_vld = 0, rd_req = 0, wr_req = 0;
  logic        rd_gnt, wr_gnt, throttle;

  int n_chk = 0, n_err = 0;
  int m_pos = 0, m_last = 31, m_act = 0, tally = 0, cyc = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  mem_thermal_throttle u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_hot_i(cnt_hot), .cnt_cool_i(cnt_cool),
    .win_len_i(win_len), .level_i(level), .trip_vld_i(trip_vld),
    .rd_req_i(rd_req), .wr_req_i(wr_req),
    .rd_gnt_o(rd_gnt), .wr_gnt_o(wr_gnt), .throttle_o(throttle));

  function automatic int pick(int lv);
    if (lv < 4) return (cnt_hot >> (8 * (3 - lv))) & 255;
    return (cnt_cool >> (8 * (7 - lv))) & 255;
  endfunction

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (cyc %0d)", r, act, exp, cyc);
    end
  endtask

  // requirement model, advanced on each active edge
  always @(posedge clk) begin
    if (rst_ni) begin
      cyc++;
      if (m_pos == m_last) begin
        chk({tag, " R4/R5 per-window count"}, tally,
            (m_act < m_last + 1) ? m_act : m_last + 1);
        tally  = 0;
        m_pos  = 0;
        m_last = (win_len < 31) ? 31 : int'(win_len);
        m_act  = trip_vld ? pick(level) : 0;
      end else m_pos++;
    end
  end

  task automatic step();
    @(negedge clk);
    chk({tag, " throttle"}, throttle, (m_pos < m_act) ? 1 : 0);
    chk("R8 rd_gnt", rd_gnt, rd_req & !(m_pos < m_act));
    chk("R8 wr_gnt", wr_gnt, wr_req & !(m_pos < m_act));
    if (throttle) tally++;
    rd_req = cyc[0];
    wr_req = cyc[1] ^ cyc[3];
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    cnt_hot = 32'hFFFF_FFFF; trip_vld = 1; rd_req = 1; wr_req = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset throttle", throttle, 0);
    chk("R1 reset rd_gnt", rd_gnt, 1);
    chk("R1 reset wr_gnt", wr_gnt, 1);
    cnt_hot = 0;
    rst_ni = 1;
    tag = "R1"; run(32);
    tag = "R9"; run(70);

    // R3/R4: descending counts, every level code
    cnt_hot = 32'h28201810; cnt_cool = 32'h0C080402; win_len = 63;
    for (int lv = 0; lv < 8; lv++) begin
      level = 3'(lv); tag = "R3";
      run(140);
    end

    // R2: window length encoding and clamp
    level = 0;
    foreach (win_len[i]) ;
    begin
      int wl[6] = '{0, 20, 30, 31, 100, 255};
      for (int k = 0; k < 6; k++) begin
        win_len = 8'(wl[k]); tag = "R2";
        run(2 * (wl[k] + 1) + 70);
      end
    end

    // R5: count at or beyond window length
    cnt_hot = 32'hC8_40_3F_FF; win_len = 63;
    for (int lv = 0; lv < 4; lv++) begin
      level = 3'(lv); tag = "R5"; run(140);
    end

    // R6: trip not valid
    trip_vld = 0; level = 0; tag = "R6"; run(150);
    trip_vld = 1;

    // R7: mid-window changes of level, counts, length and valid flag
    cnt_hot = 32'h30201008; cnt_cool = 32'h06040201; win_len = 40;
    for (int k = 0; k < 40; k++) begin
      tag = "R7";
      level = 3'((k * 5) % 8);
      trip_vld = (k % 7) != 3;
      win_len = (k % 3 == 0) ? 8'd40 : 8'd50;
      run(17 + (k % 11));
    end
    level = 7; cnt_cool = 32'h0; tag = "R9"; run(120);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule